// File: doc/BRIEF.md
# Store Effective Address Generator with Base Update

This block computes the memory address for a fixed-point store, one operation per cycle. The decode stage gives it the addressing form, an update flag, the base register number, the base register's value, the index register's value and the 16-bit immediate field. Three forms are supported:

- displacement, which adds a sign-extended 16-bit immediate;
- scaled displacement, which adds a 14-bit immediate with two zero bits appended below it, then sign-extended;
- indexed, which adds the index register value.

In the non-update forms, a base register number of zero means a base of zero. An update form always uses the base register's value as its base. An update form also asks for the computed address to be written back into the base register. It is illegal when the base register number is zero.

The outputs are registered. The address, writeback enable, writeback register number and illegal flag appear together with the output valid, one clock after the request. The register file and the store itself are handled by the surrounding pipeline.

Top module: `store_ea_gen`

## Requirements
- R1: After a synchronous reset, out_valid, out_wb_en and out_illegal are all 0.
- R2: Form code 0 (displacement): out_ea equals the base plus in_imm sign-extended from bit 15 to 64 bits.
- R3: Form code 1 (scaled displacement): out_ea equals the base plus the sign extension of {in_imm[15:2], 2'b00}. The two low bits of in_imm have no effect.
- R4: Form code 2 (indexed): out_ea equals the base plus in_idx_val, and in_imm has no effect.
- R5: When in_update is 0, the base is zero if in_base_reg is 0; otherwise it is in_base_val.
- R6: When in_update is 1, the base is always in_base_val. If the operation is legal, out_wb_en is 1 and out_wb_reg equals in_base_reg.
- R7: An update request with in_base_reg equal to 0 sets out_illegal to 1 and out_wb_en to 0.
- R8: The address sum wraps modulo 2^64.
- R9: Each request with in_valid at 1 produces out_valid at 1 exactly one cycle later, with its address and flags in that same cycle. A cycle without a request gives out_valid, out_wb_en and out_illegal all 0 one cycle later.
- R10: Form code 3 is reserved. It sets out_illegal to 1 and out_wb_en to 0, and out_ea equals the base alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_form | input | 2 | Addressing form: 0 displacement, 1 scaled, 2 indexed, 3 reserved |
| in_update | input | 1 | Write the address back into the base register |
| in_base_reg | input | 5 | Base register number |
| in_base_val | input | 64 | Base register contents |
| in_idx_val | input | 64 | Index register contents |
| in_imm | input | 16 | Immediate displacement field |
| out_valid | output | 1 | Result present |
| out_ea | output | 64 | Effective address |
| out_wb_en | output | 1 | Write the address into out_wb_reg |
| out_wb_reg | output | 5 | Writeback register number |
| out_illegal | output | 1 | Request was an illegal form |

## Verification
A wrong base choice, a wrong sign extension or a wrong scaling drop shows as a wrong out_ea on the very next cycle, for the one request that triggers it. No fault here can hide in state, because nothing is carried from one request to the next. The bench therefore sweeps every form and update setting against base register 0, 1 and 31. It uses immediates at the sign boundary and with low bits set, and values that force a carry out of bit 63, so that each such path is hit at least once. A fault in the legality check shows as a writeback to register 0 in the same output cycle.

// File: rtl/store_ea_pkg.sv
package store_ea_pkg;
  typedef enum logic [1:0] {
    FORM_DISP    = 2'd0,
    FORM_SCALED  = 2'd1,
    FORM_INDEXED = 2'd2,
    FORM_RSVD    = 2'd3
  } ea_form_e;
endpackage

// File: rtl/store_ea_base_sel.sv
module store_ea_base_sel #(
  parameter int XLEN  = 64,
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] base_reg,
  input  logic [XLEN-1:0]  base_val,
  input  logic             update,
  output logic [XLEN-1:0]  base,
  output logic             reg_is_zero
);
  always_comb begin
    reg_is_zero = (base_reg == '0);
    // An update form always takes the register value; otherwise register 0 reads as zero.
    if (update || !reg_is_zero) base = base_val;
    else                        base = '0;
  end
endmodule

// File: rtl/store_ea_offset.sv
module store_ea_offset #(
  parameter int XLEN       = 64,
  parameter int DISP_W     = 16,
  parameter int SCALE_BITS = 2
) (
  input  store_ea_pkg::ea_form_e form,
  input  logic [DISP_W-1:0]      imm,
  input  logic [XLEN-1:0]        idx_val,
  output logic [XLEN-1:0]        offset,
  output logic                   form_ok
);
  import store_ea_pkg::*;
  localparam int EXT_W = XLEN - DISP_W;

  logic [DISP_W-1:0] imm_scaled;
  logic [XLEN-1:0]   sext_plain;
  logic [XLEN-1:0]   sext_scaled;

  generate
    if (SCALE_BITS > 0) begin : g_scaled
      assign imm_scaled = {imm[DISP_W-1:SCALE_BITS], {SCALE_BITS{1'b0}}};
    end else begin : g_unscaled
      assign imm_scaled = imm;
    end
  endgenerate

  assign sext_plain  = {{EXT_W{imm[DISP_W-1]}}, imm};
  assign sext_scaled = {{EXT_W{imm_scaled[DISP_W-1]}}, imm_scaled};

  always_comb begin
    form_ok = 1'b1;
    unique case (form)
      FORM_DISP:    offset = sext_plain;
      FORM_SCALED:  offset = sext_scaled;
      FORM_INDEXED: offset = idx_val;
      default: begin
        offset  = '0;
        form_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/store_ea_gen.sv
module store_ea_gen #(
  parameter int XLEN       = 64,
  parameter int REG_W      = 5,
  parameter int DISP_W     = 16,
  parameter int SCALE_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_form,
  input  logic              in_update,
  input  logic [REG_W-1:0]  in_base_reg,
  input  logic [XLEN-1:0]   in_base_val,
  input  logic [XLEN-1:0]   in_idx_val,
  input  logic [DISP_W-1:0] in_imm,
  output logic              out_valid,
  output logic [XLEN-1:0]   out_ea,
  output logic              out_wb_en,
  output logic [REG_W-1:0]  out_wb_reg,
  output logic              out_illegal
);
  import store_ea_pkg::*;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;
  logic            reg_is_zero;
  logic            form_ok;
  logic            illegal_c;
  logic            wb_c;
  logic [XLEN-1:0] ea_c;

  store_ea_base_sel #(.XLEN(XLEN), .REG_W(REG_W)) u_base (
    .base_reg    (in_base_reg),
    .base_val    (in_base_val),
    .update      (in_update),
    .base        (base),
    .reg_is_zero (reg_is_zero)
  );

  store_ea_offset #(.XLEN(XLEN), .DISP_W(DISP_W), .SCALE_BITS(SCALE_BITS)) u_off (
    .form    (ea_form_e'(in_form)),
    .imm     (in_imm),
    .idx_val (in_idx_val),
    .offset  (offset),
    .form_ok (form_ok)
  );

  always_comb begin
    ea_c      = base + offset;   // wraps modulo 2^XLEN
    illegal_c = !form_ok || (in_update && reg_is_zero);
    wb_c      = in_update && !illegal_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wb_en   <= 1'b0;
      out_illegal <= 1'b0;
      out_ea      <= '0;
      out_wb_reg  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_wb_en   <= in_valid && wb_c;
      out_illegal <= in_valid && illegal_c;
      if (in_valid) begin
        out_ea     <= ea_c;
        out_wb_reg <= in_base_reg;
      end
    end
  end

  // R9
  wb_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_wb_en |-> out_valid);
  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R7
  illegal_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_wb_en);
  // R6
  wb_from_update_chk: assert property (@(posedge clk) disable iff (rst)
    out_wb_en |-> $past(in_update && in_valid));
  // R7
  wb_reg_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    out_wb_en |-> (out_wb_reg != '0));
  // R10
  rsvd_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_form == 2'd3) |=> out_illegal);
endmodule

// File: tb/tb_store_ea_gen.sv
module tb_store_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_form = 2'd0;
  logic        in_update = 1'b0;
  logic [4:0]  in_base_reg = 5'd0;
  logic [63:0] in_base_val = 64'd0;
  logic [63:0] in_idx_val = 64'd0;
  logic [15:0] in_imm = 16'd0;
  logic        out_valid;
  logic [63:0] out_ea;
  logic        out_wb_en;
  logic [4:0]  out_wb_reg;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_ea_gen dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_form(in_form),
    .in_update(in_update), .in_base_reg(in_base_reg), .in_base_val(in_base_val),
    .in_idx_val(in_idx_val), .in_imm(in_imm), .out_valid(out_valid),
    .out_ea(out_ea), .out_wb_en(out_wb_en), .out_wb_reg(out_wb_reg),
    .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a falling edge, check its result at the next falling edge.
  task automatic run(input logic [1:0] f, input logic u, input logic [4:0] ra,
                     input logic [63:0] bv, input logic [63:0] xv, input logic [15:0] im);
    logic [63:0] base, off, ea;
    logic ill, wb;
    in_valid = 1'b1; in_form = f; in_update = u; in_base_reg = ra;
    in_base_val = bv; in_idx_val = xv; in_imm = im;
    base = (u || ra != 5'd0) ? bv : 64'd0;
    case (f)
      2'd0: off = {{48{im[15]}}, im};
      2'd1: off = {{48{im[15]}}, im[15:2], 2'b00};
      2'd2: off = xv;
      default: off = 64'd0;
    endcase
    ea  = base + off;
    ill = (f == 2'd3) || (u && ra == 5'd0);
    wb  = u && !ill;
    @(negedge clk);
    chk("R9 valid", {63'd0, out_valid}, 64'd1);
    case (f)
      2'd0: chk("R2 ea", out_ea, ea);
      2'd1: chk("R3 ea", out_ea, ea);
      2'd2: chk("R4 ea", out_ea, ea);
      default: chk("R10 ea", out_ea, ea);
    endcase
    if (f == 2'd3) chk("R10 illegal", {63'd0, out_illegal}, {63'd0, ill});
    else           chk("R7 illegal", {63'd0, out_illegal}, {63'd0, ill});
    chk("R6 wb_en", {63'd0, out_wb_en}, {63'd0, wb});
    if (wb) chk("R6 wb_reg", {59'd0, out_wb_reg}, {59'd0, ra});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] imms [7];
    logic [63:0] bases [3];
    logic [4:0]  regs [3];
    imms  = '{16'h0000, 16'h0001, 16'h0003, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1235};
    bases = '{64'h0000_0000_0001_0000, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0000};
    regs  = '{5'd0, 5'd1, 5'd31};

    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 wb_en", {63'd0, out_wb_en}, 64'd0);
    chk("R1 illegal", {63'd0, out_illegal}, 64'd0);
    rst = 1'b0;

    // R5 directed: register 0 without update reads as zero base
    run(2'd0, 1'b0, 5'd0, 64'hDEAD_BEEF_0000_0000, 64'd0, 16'h0010);
    chk("R5 zero base", out_ea, 64'h10);
    // R8 directed: carry out of bit 63 is dropped
    run(2'd2, 1'b1, 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 16'd0);
    chk("R8 wrap", out_ea, 64'd1);
    // R3 directed: low immediate bits ignored
    run(2'd1, 1'b0, 5'd4, 64'h100, 64'd0, 16'hFFFF);
    chk("R3 low bits", out_ea, 64'hFC);

    for (int f = 0; f < 4; f++)
      for (int u = 0; u < 2; u++)
        for (int r = 0; r < 3; r++)
          for (int i = 0; i < 7; i++)
            for (int b = 0; b < 3; b++)
              run(f[1:0], u[0], regs[r], bases[b], 64'h7FFF_FFFF_FFFF_FFF8 + 64'(i), imms[i]);

    // R9 idle cycle gives no output
    in_valid = 1'b0; in_update = 1'b1; in_base_reg = 5'd0; in_form = 2'd3;
    @(negedge clk);
    chk("R9 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R9 idle wb_en", {63'd0, out_wb_en}, 64'd0);
    chk("R9 idle illegal", {63'd0, out_illegal}, 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule